// File: doc/BRIEF.md
# Wide Special Register File with Staged Commit and Sideloaded Keys

This block is an indexed bank of eight 256-bit special registers that an execution pipeline reads and writes by a 3-bit index. Two of the slots are ordinary read/write registers, a modulus and an accumulator. Two slots pass through 256-bit values from external random and pseudo-random sources. The other four are read-only windows onto two 384-bit keys that arrive on sideload inputs. Each key is seen as a low window and a high window, and both windows share the key's valid flag.

Writes do not take effect at once. A write to the modulus or the accumulator is held as a pending value. It is copied into the register when the commit strobe fires, and it is dropped when the abort strobe fires. Key loads are held in the same way until the instruction ends. A key load is applied whether that instruction commits or aborts, because the key comes from outside the instruction stream. The read port is combinational. It returns the data, a value-valid flag and an error flag that is raised when the selected key is not loaded.

Top module: `wide_sreg_file`

## Requirements
- R1: Index 0 reads the committed modulus and index 3 reads the committed accumulator. Index 1 reads `rnd_i` and index 2 reads `urnd_i`, in the same cycle.
- R2: A write to index 0 or 3 does not change the value read back until a cycle in which `commit_i` is high and `abort_i` is low. In that cycle the pending value becomes the register value.
- R3: A write in the same cycle as a commit is part of that commit. If several writes to one register come before a commit, the last one wins.
- R4: An abort discards the pending modulus and accumulator writes, including a write in the same cycle as the abort. When commit and abort are high together, abort has priority.
- R5: Writes to indices 1, 2 and 4 to 7 have no effect on any value read back, even after a commit.
- R6: Index 4 (key 0) and index 6 (key 1) return key bits [255:0]. Index 5 (key 0) and index 7 (key 1) return key bits [383:256] in the low 128 bits, with the upper 128 bits read as zero.
- R7: `rd_vld_o` is 1 for indices 0 to 3. For indices 4 to 7 it equals the valid flag of the selected key.
- R8: Reading a window of a key that is not valid returns all zeros and sets `rd_err_o`. Otherwise `rd_err_o` is 0.
- R9: A key load is staged and takes effect at the next commit, which may be in the same cycle as the load. A load with `key_vld_i` low clears the key: the valid flag and the data both become zero.
- R10: A pending key load is also applied on an abort.
- R11: After reset the modulus and the accumulator read as zero, both keys are invalid, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_idx_i | input | 3 | Read index |
| rd_data_o | output | 256 | Read data |
| rd_vld_o | output | 1 | Read value is valid |
| rd_err_o | output | 1 | Read of an invalid key window |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 3 | Write index |
| wr_data_i | input | 256 | Write data |
| commit_i | input | 1 | Commit the staged state |
| abort_i | input | 1 | Abort the staged register writes |
| rnd_i | input | 256 | Value from the random source |
| urnd_i | input | 256 | Value from the pseudo-random source |
| key_ld_i | input | 2 | Key load strobe, one bit per key |
| key_vld_i | input | 2 | Valid flag of the key being loaded |
| key_data_i | input | 2x384 | Data of the key being loaded |

## Verification
Two pairs of events can land in the same cycle. The first is a register write together with a commit or an abort. The second is a key load together with the end of an instruction, which may be a commit or an abort. Directed cases drive each pair in one cycle, including commit and abort together. The random phase sets the write, load, commit and abort strobes independently in every cycle. After each cycle all eight indices are read and compared with a bench model that applies the order given in the requirements: staging first, then abort before commit for the registers, and key loads applied on either strobe.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  localparam int DATA_W   = 256;
  localparam int KEY_W    = 384;
  localparam int NUM_KEYS = 2;
  localparam int IDX_W    = 3;
  localparam int HI_W     = KEY_W - DATA_W;

  localparam logic [IDX_W-1:0] IDX_MOD  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_RND  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_URND = 3'd2;
  localparam logic [IDX_W-1:0] IDX_ACC  = 3'd3;
endpackage

// File: rtl/wsr_stage.sv
// Plain register with a pending copy; commit copies, abort discards.
module wsr_stage #(
  parameter int W = 256
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         commit_i,
  input  logic         abort_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] val_q, pend_q, pend_nxt;
  logic         pf_q, pf_nxt;

  always_comb begin
    pf_nxt   = wr_i | pf_q;
    pend_nxt = wr_i ? wr_data_i : pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      pend_q <= '0;
      pf_q   <= 1'b0;
    end else if (abort_i) begin
      pf_q   <= 1'b0;
    end else if (commit_i) begin
      if (pf_nxt) val_q <= pend_nxt;
      pf_q   <= 1'b0;
    end else begin
      pf_q   <= pf_nxt;
      pend_q <= pend_nxt;
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/wsr_key_slot.sv
// Sideloaded key; staged load applies on commit or abort.
module wsr_key_slot #(
  parameter int W = 384
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic         ld_vld_i,
  input  logic [W-1:0] ld_data_i,
  input  logic         commit_i,
  input  logic         abort_i,
  output logic [W-1:0] key_o,
  output logic         vld_o
);
  logic [W-1:0] key_q, pend_q, pend_nxt;
  logic         vld_q, pvld_q, pvld_nxt, pf_q, pf_nxt;
  logic         apply;

  assign apply = commit_i | abort_i;

  always_comb begin
    pf_nxt   = ld_i | pf_q;
    pvld_nxt = ld_i ? ld_vld_i : pvld_q;
    pend_nxt = ld_i ? (ld_vld_i ? ld_data_i : '0) : pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q  <= '0;
      vld_q  <= 1'b0;
      pend_q <= '0;
      pvld_q <= 1'b0;
      pf_q   <= 1'b0;
    end else if (apply) begin
      if (pf_nxt) begin
        key_q <= pend_nxt;
        vld_q <= pvld_nxt;
      end
      pf_q <= 1'b0;
    end else begin
      pf_q   <= pf_nxt;
      pvld_q <= pvld_nxt;
      pend_q <= pend_nxt;
    end
  end

  assign key_o = key_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/wsr_rd_mux.sv
module wsr_rd_mux
  import wsr_pkg::*;
(
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [DATA_W-1:0]               mod_i,
  input  logic [DATA_W-1:0]               acc_i,
  input  logic [DATA_W-1:0]               rnd_i,
  input  logic [DATA_W-1:0]               urnd_i,
  input  logic [NUM_KEYS-1:0][KEY_W-1:0]  key_i,
  input  logic [NUM_KEYS-1:0]             key_vld_i,
  output logic [DATA_W-1:0]               data_o,
  output logic                            vld_o,
  output logic                            err_o
);
  logic             is_key, hi_half;
  logic             sel_k;
  logic [KEY_W-1:0] sel_key;
  logic [DATA_W-1:0] win;

  // key windows: idx = 4 + 2*key + half
  assign is_key  = idx_i[2];
  assign sel_k   = idx_i[1];
  assign hi_half = idx_i[0];
  assign sel_key = key_i[sel_k];
  assign win     = hi_half ? {{(DATA_W-HI_W){1'b0}}, sel_key[KEY_W-1:DATA_W]}
                           : sel_key[DATA_W-1:0];

  always_comb begin
    data_o = '0;
    vld_o  = 1'b1;
    err_o  = 1'b0;
    if (is_key) begin
      vld_o  = key_vld_i[sel_k];
      err_o  = ~key_vld_i[sel_k];
      data_o = key_vld_i[sel_k] ? win : '0;
    end else begin
      unique case (idx_i)
        IDX_MOD:  data_o = mod_i;
        IDX_RND:  data_o = rnd_i;
        IDX_URND: data_o = urnd_i;
        IDX_ACC:  data_o = acc_i;
        default:  data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wide_sreg_file.sv
module wide_sreg_file
  import wsr_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [IDX_W-1:0]                rd_idx_i,
  output logic [DATA_W-1:0]               rd_data_o,
  output logic                            rd_vld_o,
  output logic                            rd_err_o,
  input  logic                            wr_en_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  input  logic                            commit_i,
  input  logic                            abort_i,
  input  logic [DATA_W-1:0]               rnd_i,
  input  logic [DATA_W-1:0]               urnd_i,
  input  logic [NUM_KEYS-1:0]             key_ld_i,
  input  logic [NUM_KEYS-1:0]             key_vld_i,
  input  logic [NUM_KEYS-1:0][KEY_W-1:0]  key_data_i
);
  logic [DATA_W-1:0]              mod_q, acc_q;
  logic [NUM_KEYS-1:0][KEY_W-1:0] key_q;
  logic [NUM_KEYS-1:0]            key_vld_q;

  // writes to rnd, urnd and key windows are dropped here
  wsr_stage #(.W(DATA_W)) u_mod (
    .clk_i, .rst_ni,
    .wr_i      (wr_en_i && wr_idx_i == IDX_MOD),
    .wr_data_i,
    .commit_i, .abort_i,
    .val_o     (mod_q)
  );

  wsr_stage #(.W(DATA_W)) u_acc (
    .clk_i, .rst_ni,
    .wr_i      (wr_en_i && wr_idx_i == IDX_ACC),
    .wr_data_i,
    .commit_i, .abort_i,
    .val_o     (acc_q)
  );

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    wsr_key_slot #(.W(KEY_W)) u_slot (
      .clk_i, .rst_ni,
      .ld_i      (key_ld_i[k]),
      .ld_vld_i  (key_vld_i[k]),
      .ld_data_i (key_data_i[k]),
      .commit_i, .abort_i,
      .key_o     (key_q[k]),
      .vld_o     (key_vld_q[k])
    );
  end

  wsr_rd_mux u_rd (
    .idx_i     (rd_idx_i),
    .mod_i     (mod_q),
    .acc_i     (acc_q),
    .rnd_i,
    .urnd_i,
    .key_i     (key_q),
    .key_vld_i (key_vld_q),
    .data_o    (rd_data_o),
    .vld_o     (rd_vld_o),
    .err_o     (rd_err_o)
  );
endmodule

// File: rtl/wsr_file_chk.sv
module wsr_file_chk
  import wsr_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [IDX_W-1:0]     rd_idx_i,
  input logic [DATA_W-1:0]    rd_data_o,
  input logic                 rd_vld_o,
  input logic                 rd_err_o,
  input logic                 commit_i,
  input logic                 abort_i,
  input logic [DATA_W-1:0]    rnd_i,
  input logic [DATA_W-1:0]    urnd_i,
  input logic [DATA_W-1:0]    mod_q,
  input logic [DATA_W-1:0]    acc_q,
  input logic [NUM_KEYS-1:0]  key_vld_q
);
  a_r1_rnd_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_i == IDX_RND |-> rd_data_o == rnd_i);
  a_r1_urnd_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_idx_i == IDX_URND |-> rd_data_o == urnd_i);
  a_r2_hold_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(mod_q));
  a_r4_abort_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> $stable(acc_q));
  a_r4_abort_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> $stable(mod_q));
  a_r6_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i[2] && rd_idx_i[0]) |-> rd_data_o[DATA_W-1:KEY_W-DATA_W] == '0);
  a_r7_plain_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_idx_i[2] |-> rd_vld_o && !rd_err_o);
  a_r8_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> rd_data_o == '0 && !rd_vld_o);
  a_r9_key_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_i || abort_i) |=> $stable(key_vld_q));
endmodule

bind wide_sreg_file wsr_file_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_idx_i  (rd_idx_i),
  .rd_data_o (rd_data_o),
  .rd_vld_o  (rd_vld_o),
  .rd_err_o  (rd_err_o),
  .commit_i  (commit_i),
  .abort_i   (abort_i),
  .rnd_i     (rnd_i),
  .urnd_i    (urnd_i),
  .mod_q     (mod_q),
  .acc_q     (acc_q),
  .key_vld_q (key_vld_q)
);

// File: tb/wide_sreg_file_tb.sv
module wide_sreg_file_tb;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        rd_idx = '0;
  logic [255:0]      rd_data;
  logic              rd_vld, rd_err;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_idx = '0;
  logic [255:0]      wr_data = '0;
  logic              commit = 1'b0, abort = 1'b0;
  logic [255:0]      rnd = '0, urnd = '0;
  logic [1:0]        kld = '0, kvld = '0;
  logic [1:0][383:0] kdata = '0;

  int n_tests = 0;
  int n_fail  = 0;

  logic [255:0] m_mod = '0, m_acc = '0, p_mod = '0, p_acc = '0;
  bit           pf_mod = 0, pf_acc = 0;
  logic [383:0] m_key [2];
  logic [383:0] p_key [2];
  bit           m_kv [2];
  bit           p_kv [2];
  bit           pf_k [2];

  always #4 clk = ~clk;

  wide_sreg_file u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_vld_o(rd_vld), .rd_err_o(rd_err),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .commit_i(commit), .abort_i(abort),
    .rnd_i(rnd), .urnd_i(urnd),
    .key_ld_i(kld), .key_vld_i(kvld), .key_data_i(kdata)
  );

  function automatic logic [255:0] rand256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [383:0] rand384();
    logic [383:0] r;
    for (int i = 0; i < 12; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic void expect_rd(input int idx, output logic [255:0] d,
                                    output bit v, output bit e);
    int k;
    v = 1; e = 0; d = '0;
    case (idx)
      0: d = m_mod;
      1: d = rnd;
      2: d = urnd;
      3: d = m_acc;
      default: begin
        k = (idx >> 1) & 1;
        if (!m_kv[k]) begin v = 0; e = 1; d = '0; end
        else if (idx & 1) d = {128'd0, m_key[k][383:256]};
        else d = m_key[k][255:0];
      end
    endcase
  endfunction

  task automatic check_all(input string tag);
    logic [255:0] d;
    bit v, e;
    for (int i = 0; i < 8; i++) begin
      rd_idx = i[2:0];
      #1;
      expect_rd(i, d, v, e);
      n_tests++;
      if (rd_data !== d || rd_vld !== v || rd_err !== e) begin
        n_fail++;
        $display("FAIL %s idx=%0d actual data=%h vld=%b err=%b expected data=%h vld=%b err=%b",
                 tag, i, rd_data, rd_vld, rd_err, d, v, e);
      end
    end
  endtask

  // one clock with current strobes; model updates in the same order as the spec
  task automatic cycle();
    @(posedge clk);
    if (wr_en && wr_idx == 3'd0) begin p_mod = wr_data; pf_mod = 1; end
    if (wr_en && wr_idx == 3'd3) begin p_acc = wr_data; pf_acc = 1; end
    for (int k = 0; k < 2; k++)
      if (kld[k]) begin
        p_key[k] = kvld[k] ? kdata[k] : '0;
        p_kv[k]  = kvld[k];
        pf_k[k]  = 1;
      end
    if (abort) begin
      pf_mod = 0; pf_acc = 0;
    end else if (commit) begin
      if (pf_mod) m_mod = p_mod;
      if (pf_acc) m_acc = p_acc;
      pf_mod = 0; pf_acc = 0;
    end
    if (abort || commit)
      for (int k = 0; k < 2; k++)
        if (pf_k[k]) begin m_key[k] = p_key[k]; m_kv[k] = p_kv[k]; pf_k[k] = 0; end
    #1;
    wr_en = 0; commit = 0; abort = 0; kld = '0;
  endtask

  task automatic do_wr(input int idx, input logic [255:0] d, input bit c, input bit a);
    wr_en = 1; wr_idx = idx[2:0]; wr_data = d; commit = c; abort = a;
    cycle();
  endtask

  task automatic do_key(input int k, input bit v, input logic [383:0] d,
                        input bit c, input bit a);
    kld[k] = 1; kvld[k] = v; kdata[k] = d; commit = c; abort = a;
    cycle();
  endtask

  task automatic do_end(input bit c, input bit a);
    commit = c; abort = a;
    cycle();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 2; k++) begin
      m_key[k] = '0; p_key[k] = '0; m_kv[k] = 0; p_kv[k] = 0; pf_k[k] = 0;
    end
    rnd = rand256(); urnd = rand256();
    #20;
    rst_n = 1'b1;
    #3;
    check_all("R11");

    // R2 staging
    do_wr(0, rand256(), 0, 0);
    check_all("R2");
    do_end(1, 0);
    check_all("R2");
    // R3 last write wins; same-cycle write commits
    do_wr(3, rand256(), 0, 0);
    do_wr(3, rand256(), 0, 0);
    do_end(1, 0);
    check_all("R3");
    do_wr(0, rand256(), 1, 0);
    check_all("R3");
    // R4 abort, and abort over commit
    do_wr(0, rand256(), 0, 0);
    do_end(0, 1);
    check_all("R4");
    do_wr(3, rand256(), 1, 1);
    check_all("R4");
    // R5 writes to non-writable slots
    do_wr(1, rand256(), 0, 0);
    do_wr(2, rand256(), 0, 0);
    for (int i = 4; i < 8; i++) do_wr(i, rand256(), 0, 0);
    do_end(1, 0);
    check_all("R5");
    // R9 key load staged, then commit; R6 windows
    do_key(0, 1, rand384(), 0, 0);
    check_all("R9");
    do_end(1, 0);
    check_all("R6");
    // R10 load applied on abort
    do_key(1, 1, rand384(), 0, 1);
    check_all("R10");
    // R9 clear with valid low, same-cycle commit; R8 error read
    do_key(0, 0, rand384(), 1, 0);
    check_all("R8");
    do_key(0, 1, rand384(), 1, 1);
    check_all("R10");

    // random phase
    for (int it = 0; it < 500; it++) begin
      wr_en   = ($urandom % 2) == 0;
      wr_idx  = 3'($urandom % 8);
      wr_data = rand256();
      commit  = ($urandom % 3) == 0;
      abort   = ($urandom % 5) == 0;
      for (int k = 0; k < 2; k++) begin
        kld[k]   = ($urandom % 6) == 0;
        kvld[k]  = ($urandom % 4) != 0;
        kdata[k] = rand384();
      end
      rnd = rand256(); urnd = rand256();
      cycle();
      check_all("R1/R6/R7/R8");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule